// File: doc/BRIEF.md
# Serial RAM Byte Access Master

This block lets a prediction core fetch and store single signed weight bytes held in an external serial RAM. The core presents an 11-bit weight address, a direction flag and, for stores, a data byte. The block then runs one complete chip-select framed transfer on a four-wire serial link. When the transfer ends it raises a one-cycle completion strobe. For a fetch, the byte read from the RAM is returned with that strobe.

Two settings control the serial link, and each has a load strobe of its own. The first is a 2-bit rate code that sets how fast the serial clock runs compared with the system clock. The second is a 3-bit guard count. The guard count sets how many system cycles pass after chip select goes low before clocking begins, and how many pass after chip select is released before the block takes another request. The block copies both settings when it accepts a request. A setting written while a transfer is running only affects the next transfer.

Top module: `spi_ram_master`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, and `busy` and `done` are low. The rate code resets to 2 (half period 4 cycles) and the guard count resets to 3.
- R2: Each transfer is 32 bits, sent MSB first with 32 rising serial clock edges. The bits are an instruction byte (0x03 for a fetch, 0x02 for a store), then the address zero-extended to 16 bits, then a data byte. For a fetch the data byte is 0x00. For a store it is `req_wdata`.
- R3: The serial clock is low whenever chip select is high. `ram_mosi` changes only while the serial clock is low. `ram_miso` is sampled on rising serial clock edges.
- R4: With rate code d, every high phase and every low phase of the serial clock inside a transfer lasts 2^d system cycles. This gives 0 = /2, 1 = /4, 2 = /8, 3 = /16.
- R5: The first rising serial clock edge comes exactly g + 2^d system cycles after chip select falls, where g is the guard count.
- R6: Chip select rises in the same cycle as the last falling serial clock edge. `busy` then stays high for exactly g more cycles.
- R7: `done` is high for exactly one cycle, the first cycle in which chip select is high again. In that cycle a fetch presents the 8 bits sampled during the data byte on `rdata`, MSB first.
- R8: A request is taken only while `busy` is low. A request raised while `busy` is high starts no transfer and does not change the running one.
- R9: The rate code and guard count are captured when a request is taken. Loading new values during a transfer changes neither its clock timing nor its guards.
- R10: `cfg_div_we` loads `cfg_div_val` and `cfg_guard_we` loads `cfg_guard_val`. The loaded values are used by the next transfer taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cfg_div_we | input | 1 | Load strobe for the rate code |
| cfg_div_val | input | 2 | Rate code (half period 2^code cycles) |
| cfg_guard_we | input | 1 | Load strobe for the guard count |
| cfg_guard_val | input | 3 | Guard count in system cycles |
| req | input | 1 | Request a transfer (taken when busy is low) |
| req_we | input | 1 | 1 = store, 0 = fetch |
| req_addr | input | 11 | Weight address |
| req_wdata | input | 8 | Byte to store |
| busy | output | 1 | Transfer or trailing guard in progress |
| done | output | 1 | One-cycle completion strobe |
| rdata | output | 8 | Fetched byte, valid with done |
| ram_cs_n | output | 1 | RAM chip select, active low |
| ram_sck | output | 1 | RAM serial clock |
| ram_mosi | output | 1 | Serial data to the RAM |
| ram_miso | input | 1 | Serial data from the RAM |

## Verification
The bench runs transfers against a behavioural serial RAM model. Each transfer draws the rate code, guard count, direction and address at random, and directed cases cover both ends of each setting: rate codes 0 and 3, guard counts 0 and 7, and addresses 0 and 2047. Stores followed by fetches of the same address show whether bits are sampled on the correct serial clock edge and in the correct order. Fetches of preset contents that vary from byte to byte show whether the address field is built correctly. Some transfers load new settings mid-transfer, and their timing exposes any setting that is not held for the whole transfer. Other transfers raise a second request while busy, and the number of frames the model sees exposes any request taken when it should not be.

// File: rtl/spi_ram_pkg.sv
package spi_ram_pkg;

  localparam int INSTR_W      = 8;
  localparam int ADDR_FIELD_W = 16;
  localparam logic [INSTR_W-1:0] INSTR_FETCH = 8'h03;
  localparam logic [INSTR_W-1:0] INSTR_STORE = 8'h02;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_TRAIL
  } xfer_state_e;

  // Serial clock half period in system cycles for a rate code.
  function automatic int unsigned half_cycles(input int unsigned code);
    return 32'd1 << code;
  endfunction

  // Total bits clocked in one transfer.
  function automatic int unsigned frame_bits(input int unsigned data_w);
    return INSTR_W + ADDR_FIELD_W + data_w;
  endfunction

endpackage

// File: rtl/sr_cfg_regs.sv
module sr_cfg_regs #(
  parameter int DIV_W     = 2,
  parameter int GUARD_W   = 3,
  parameter int DIV_RST   = 2,
  parameter int GUARD_RST = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               div_we,
  input  logic [DIV_W-1:0]   div_val,
  input  logic               guard_we,
  input  logic [GUARD_W-1:0] guard_val,
  output logic [DIV_W-1:0]   div_q,
  output logic [GUARD_W-1:0] guard_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= DIV_W'(DIV_RST);
      guard_q <= GUARD_W'(GUARD_RST);
    end else begin
      if (div_we)   div_q   <= div_val;
      if (guard_we) guard_q <= guard_val;
    end
  end

endmodule

// File: rtl/sr_sck_gen.sv
module sr_sck_gen #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] half_m1,
  output logic             sck,
  output logic             rise_now,
  output logic             fall_now
);

  logic [CNT_W-1:0] cnt_q;
  logic             edge_now;

  assign edge_now = run && (cnt_q == half_m1);
  assign rise_now = edge_now && !sck;
  assign fall_now = edge_now && sck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck   <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0;
      sck   <= 1'b0;
    end else if (edge_now) begin
      cnt_q <= '0;
      sck   <= ~sck;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/sr_seq.sv
module sr_seq
  import spi_ram_pkg::*;
#(
  parameter int ADDR_W  = 11,
  parameter int DATA_W  = 8,
  parameter int DIV_W   = 2,
  parameter int GUARD_W = 3,
  parameter int CNT_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req,
  input  logic               req_we,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic [DIV_W-1:0]   cfg_div,
  input  logic [GUARD_W-1:0] cfg_guard,
  input  logic               rise_now,
  input  logic               fall_now,
  input  logic               miso,
  output logic               run,
  output logic [CNT_W-1:0]   half_m1,
  output logic [DIV_W-1:0]   act_div,
  output logic [GUARD_W-1:0] act_guard,
  output logic               cs_n,
  output logic               mosi,
  output logic               busy,
  output logic               done,
  output logic [DATA_W-1:0]  rdata
);

  localparam int FRAME_W = frame_bits(DATA_W);
  localparam int BIT_W   = $clog2(FRAME_W);

  xfer_state_e          state_q;
  logic [FRAME_W-1:0]   frame_q;
  logic [BIT_W-1:0]     bit_q;
  logic [GUARD_W-1:0]   wait_q;
  logic [DATA_W-1:0]    rx_q;
  logic [FRAME_W-1:0]   new_frame;
  logic                 take;
  logic                 last_bit;

  function automatic logic [FRAME_W-1:0] build_frame(
    input logic              we,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wd
  );
    logic [INSTR_W-1:0] instr;
    instr = we ? INSTR_STORE : INSTR_FETCH;
    return {instr, ADDR_FIELD_W'(addr), (we ? wd : {DATA_W{1'b0}})};
  endfunction

  assign new_frame = build_frame(req_we, req_addr, req_wdata);
  assign take      = (state_q == ST_IDLE) && req;
  assign last_bit  = (bit_q == BIT_W'(FRAME_W - 1));
  assign run       = (state_q == ST_SHIFT);
  assign busy      = (state_q != ST_IDLE);
  assign half_m1   = CNT_W'(half_cycles(32'(act_div)) - 32'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      frame_q   <= '0;
      bit_q     <= '0;
      wait_q    <= '0;
      rx_q      <= '0;
      act_div   <= '0;
      act_guard <= '0;
      cs_n      <= 1'b1;
      mosi      <= 1'b0;
      done      <= 1'b0;
      rdata     <= '0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (take) begin
            act_div   <= cfg_div;
            act_guard <= cfg_guard;
            frame_q   <= new_frame;
            mosi      <= new_frame[FRAME_W-1];
            bit_q     <= '0;
            cs_n      <= 1'b0;
            if (cfg_guard == '0) begin
              state_q <= ST_SHIFT;
            end else begin
              wait_q  <= cfg_guard - 1'b1;
              state_q <= ST_LEAD;
            end
          end
        end
        ST_LEAD: begin
          if (wait_q == '0) state_q <= ST_SHIFT;
          else              wait_q  <= wait_q - 1'b1;
        end
        ST_SHIFT: begin
          if (rise_now) rx_q <= {rx_q[DATA_W-2:0], miso};
          if (fall_now) begin
            if (last_bit) begin
              cs_n  <= 1'b1;
              done  <= 1'b1;
              rdata <= rx_q;
              if (act_guard == '0) begin
                state_q <= ST_IDLE;
              end else begin
                wait_q  <= act_guard - 1'b1;
                state_q <= ST_TRAIL;
              end
            end else begin
              bit_q   <= bit_q + 1'b1;
              frame_q <= frame_q << 1;
              mosi    <= frame_q[FRAME_W-2];
            end
          end
        end
        ST_TRAIL: begin
          if (wait_q == '0) state_q <= ST_IDLE;
          else              wait_q  <= wait_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_ram_master.sv
module spi_ram_master #(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 8,
  parameter int DIV_W     = 2,
  parameter int GUARD_W   = 3,
  parameter int DIV_RST   = 2,
  parameter int GUARD_RST = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_div_we,
  input  logic [DIV_W-1:0]   cfg_div_val,
  input  logic               cfg_guard_we,
  input  logic [GUARD_W-1:0] cfg_guard_val,
  input  logic               req,
  input  logic               req_we,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               busy,
  output logic               done,
  output logic [DATA_W-1:0]  rdata,
  output logic               ram_cs_n,
  output logic               ram_sck,
  output logic               ram_mosi,
  input  logic               ram_miso
);

  localparam int CNT_W = 2 ** DIV_W;

  logic [DIV_W-1:0]   cfg_div;
  logic [GUARD_W-1:0] cfg_guard;
  logic [DIV_W-1:0]   act_div;
  logic [GUARD_W-1:0] act_guard;
  logic [CNT_W-1:0]   half_m1;
  logic               run;
  logic               rise_now;
  logic               fall_now;

  sr_cfg_regs #(
    .DIV_W    (DIV_W),
    .GUARD_W  (GUARD_W),
    .DIV_RST  (DIV_RST),
    .GUARD_RST(GUARD_RST)
  ) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .div_we   (cfg_div_we),
    .div_val  (cfg_div_val),
    .guard_we (cfg_guard_we),
    .guard_val(cfg_guard_val),
    .div_q    (cfg_div),
    .guard_q  (cfg_guard)
  );

  sr_sck_gen #(
    .CNT_W(CNT_W)
  ) u_sck (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .half_m1 (half_m1),
    .sck     (ram_sck),
    .rise_now(rise_now),
    .fall_now(fall_now)
  );

  sr_seq #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .DIV_W  (DIV_W),
    .GUARD_W(GUARD_W),
    .CNT_W  (CNT_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .req_we   (req_we),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .cfg_div  (cfg_div),
    .cfg_guard(cfg_guard),
    .rise_now (rise_now),
    .fall_now (fall_now),
    .miso     (ram_miso),
    .run      (run),
    .half_m1  (half_m1),
    .act_div  (act_div),
    .act_guard(act_guard),
    .cs_n     (ram_cs_n),
    .mosi     (ram_mosi),
    .busy     (busy),
    .done     (done),
    .rdata    (rdata)
  );

endmodule

// File: rtl/spi_ram_master_chk.sv
module spi_ram_master_chk
  import spi_ram_pkg::*;
#(
  parameter int DIV_W   = 2,
  parameter int GUARD_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busy,
  input logic               done,
  input logic               ram_cs_n,
  input logic               ram_sck,
  input logic               ram_mosi,
  input logic [DIV_W-1:0]   act_div,
  input logic [GUARD_W-1:0] act_guard
);

  logic        sck_d;
  logic        seen_q;
  logic [15:0] run_q;
  logic        toggle;
  logic [15:0] half_exp;

  assign toggle   = (ram_sck != sck_d);
  assign half_exp = 16'(half_cycles(32'(act_div)));

  // Cycles since the last serial clock toggle inside a transfer.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d  <= 1'b0;
      seen_q <= 1'b0;
      run_q  <= '0;
    end else begin
      sck_d <= ram_sck;
      if (ram_cs_n) begin
        seen_q <= 1'b0;
        run_q  <= '0;
      end else if (toggle) begin
        seen_q <= 1'b1;
        run_q  <= 16'd1;
      end else if (run_q != 16'hFFFF) begin
        run_q <= run_q + 16'd1;
      end
    end
  end

  a_r1_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ram_cs_n && !ram_sck));

  a_r3_sck_parked: assert property (@(posedge clk) disable iff (!rst_n)
    ram_cs_n |-> !ram_sck);

  a_r3_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_sck && !ram_cs_n) |-> $stable(ram_mosi));

  a_r4_half_period: assert property (@(posedge clk) disable iff (!rst_n)
    (toggle && seen_q && !ram_cs_n) |-> (run_q == half_exp));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_done_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ram_cs_n);

  a_r9_settings_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(act_div) && $stable(act_guard)));

endmodule

bind spi_ram_master spi_ram_master_chk #(
  .DIV_W  (DIV_W),
  .GUARD_W(GUARD_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done     (done),
  .ram_cs_n (ram_cs_n),
  .ram_sck  (ram_sck),
  .ram_mosi (ram_mosi),
  .act_div  (act_div),
  .act_guard(act_guard)
);

// File: tb/spi_ram_master_tb.sv
`timescale 1ns/1ps
module spi_ram_master_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_div_we = 1'b0;
  logic [1:0]  cfg_div_val = '0;
  logic        cfg_guard_we = 1'b0;
  logic [2:0]  cfg_guard_val = '0;
  logic        req = 1'b0;
  logic        req_we = 1'b0;
  logic [10:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        busy, done, ram_cs_n, ram_sck, ram_mosi;
  logic [7:0]  rdata;
  logic        ram_miso = 1'b0;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  spi_ram_master u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_div_we(cfg_div_we), .cfg_div_val(cfg_div_val),
    .cfg_guard_we(cfg_guard_we), .cfg_guard_val(cfg_guard_val),
    .req(req), .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rdata(rdata),
    .ram_cs_n(ram_cs_n), .ram_sck(ram_sck), .ram_mosi(ram_mosi), .ram_miso(ram_miso)
  );

  // ---------------- serial RAM model ----------------
  logic [7:0]  m_mem [2048];
  logic [7:0]  exp_mem [2048];
  logic [31:0] m_sh;
  int          m_cnt;
  logic [7:0]  m_instr;
  logic [15:0] m_addr;
  logic [7:0]  m_dout;
  int          m_frames = 0;

  always @(negedge ram_cs_n) begin
    m_cnt = 0; m_sh = '0; ram_miso = 1'b0;
  end

  always @(posedge ram_sck) if (!ram_cs_n) begin
    m_sh  = {m_sh[30:0], ram_mosi};
    m_cnt = m_cnt + 1;
    if (m_cnt == 24) begin
      m_instr = m_sh[23:16];
      m_addr  = m_sh[15:0];
      m_dout  = m_mem[m_addr[10:0]];
    end
    if (m_cnt == 32) begin
      if (m_instr == 8'h02) m_mem[m_addr[10:0]] = m_sh[7:0];
      m_frames = m_frames + 1;
    end
  end

  always @(negedge ram_sck) if (!ram_cs_n && m_cnt >= 24 && m_cnt < 32 && m_instr == 8'h03)
    ram_miso = m_dout[7 - (m_cnt - 24)];

  // ---------------- timing monitor ----------------
  int   cyc = 0, t_csf = 0, t_r1 = 0, t_csr = 0, t_bf = 0, t_done = 0, last_tog = 0;
  int   rises = 0, dones = 0, cur_half = 4;
  bit   first_rise = 1'b0, bad_half = 1'b0, mosi_bad = 1'b0, sck_at_csr = 1'b0;
  logic [7:0] rd_cap = '0;
  logic p_cs = 1'b1, p_sck = 1'b0, p_busy = 1'b0, p_mosi = 1'b0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (p_cs && !ram_cs_n) begin
      t_csf = cyc; rises = 0; first_rise = 1'b1; bad_half = 1'b0;
      mosi_bad = 1'b0; dones = 0; last_tog = cyc;
    end
    if (!p_sck && ram_sck) begin
      rises = rises + 1;
      if (first_rise) begin t_r1 = cyc; first_rise = 1'b0; end
      else if (cyc - last_tog != cur_half) bad_half = 1'b1;
      last_tog = cyc;
    end
    if (p_sck && !ram_sck) begin
      if (cyc - last_tog != cur_half) bad_half = 1'b1;
      last_tog = cyc;
    end
    if (p_sck && ram_sck && (ram_mosi != p_mosi)) mosi_bad = 1'b1;
    if (!p_cs && ram_cs_n) begin t_csr = cyc; sck_at_csr = ram_sck; end
    if (p_busy && !busy) t_bf = cyc;
    if (done) begin dones = dones + 1; t_done = cyc; rd_cap = rdata; end
    p_cs = ram_cs_n; p_sck = ram_sck; p_busy = busy; p_mosi = ram_mosi;
  end

  // ---------------- helpers ----------------
  logic [1:0] sh_div   = 2'd2;
  logic [2:0] sh_guard = 3'd3;

  function automatic int exp_half(input logic [1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 2;
      2'd2:    return 4;
      default: return 8;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [1:0] d, input logic [2:0] g);
    @(negedge clk);
    cfg_div_we = 1'b1; cfg_div_val = d; cfg_guard_we = 1'b1; cfg_guard_val = g;
    @(negedge clk);
    cfg_div_we = 1'b0; cfg_guard_we = 1'b0;
    sh_div = d; sh_guard = g;
  endtask

  task automatic run_access(input logic we, input logic [10:0] a, input logic [7:0] wd,
                            input bit chg_mid, input bit poke_busy, input string tag);
    int eh, eg, f0, n;
    eh = exp_half(sh_div); eg = int'(sh_guard); cur_half = eh; f0 = m_frames;
    @(negedge clk);
    req = 1'b1; req_we = we; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req = 1'b0;
    if (chg_mid) begin
      cfg_div_we = 1'b1; cfg_div_val = 2'($urandom);
      cfg_guard_we = 1'b1; cfg_guard_val = 3'($urandom);
      sh_div = cfg_div_val; sh_guard = cfg_guard_val;
      @(negedge clk);
      cfg_div_we = 1'b0; cfg_guard_we = 1'b0;
    end
    if (poke_busy) begin
      repeat (20) @(negedge clk);
      req = 1'b1; req_we = ~we; req_addr = ~a; req_wdata = ~wd;
      @(negedge clk);
      req = 1'b0;
    end
    n = 0;
    while (busy && n < 5000) begin @(negedge clk); n = n + 1; end
    repeat (2) @(negedge clk);
    chk(rises == 32, {tag, " R2 rising edge count"}, rises, 32);
    chk(m_instr == (we ? 8'h02 : 8'h03), {tag, " R2 instruction"}, int'(m_instr), we ? 2 : 3);
    chk(m_addr == {5'b0, a}, {tag, " R2 address field"}, int'(m_addr), int'(a));
    chk(!mosi_bad, {tag, " R3 mosi moved while sck high"}, int'(mosi_bad), 0);
    chk(!bad_half, {tag, " R4 half period"}, int'(bad_half), 0);
    chk(t_r1 - t_csf == eg + eh, {tag, " R5 lead guard"}, t_r1 - t_csf, eg + eh);
    chk(t_bf - t_csr == eg, {tag, " R6 trail guard"}, t_bf - t_csr, eg);
    chk(sck_at_csr == 1'b0, {tag, " R6 sck low at release"}, int'(sck_at_csr), 0);
    chk(dones == 1 && t_done == t_csr, {tag, " R7 done pulse"}, dones, 1);
    chk(m_frames == f0 + 1, {tag, " R8 frames per request"}, m_frames - f0, 1);
    if (chg_mid)
      chk(t_r1 - t_csf == eg + eh && !bad_half, {tag, " R9 mid-transfer settings"},
          t_r1 - t_csf, eg + eh);
    if (we) begin
      exp_mem[a] = wd;
      chk(m_mem[a] == wd, {tag, " R2 stored byte"}, int'(m_mem[a]), int'(wd));
    end else begin
      chk(rd_cap == exp_mem[a], {tag, " R7 fetched byte"}, int'(rd_cap), int'(exp_mem[a]));
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    checks = checks + 1;
    errors = errors + 1;
    $display("FAIL R8 watchdog: actual hung expected idle");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 2048; i++) begin
      m_mem[i]   = 8'(i * 37 + 11);
      exp_mem[i] = 8'(i * 37 + 11);
    end
    repeat (4) @(negedge clk);
    chk(ram_cs_n === 1'b1 && ram_sck === 1'b0, "R1 lines in reset", int'(ram_cs_n), 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(ram_cs_n == 1'b1 && ram_sck == 1'b0 && busy == 1'b0 && done == 1'b0,
        "R1 lines after reset", int'({ram_cs_n, ram_sck, busy, done}), 8);
    // R1: defaults (half period 4, guard 3) observed on the first transfer
    run_access(1'b0, 11'd5, 8'h00, 1'b0, 1'b0, "R1 default");
    // R10: load fastest rate, zero guard
    set_cfg(2'd0, 3'd0);
    run_access(1'b1, 11'd2047, 8'hA5, 1'b0, 1'b0, "R10 fast store");
    run_access(1'b0, 11'd2047, 8'h00, 1'b0, 1'b0, "R10 fast fetch");
    set_cfg(2'd3, 3'd7);
    run_access(1'b1, 11'd0, 8'h5A, 1'b0, 1'b0, "slow store");
    run_access(1'b0, 11'd0, 8'h00, 1'b0, 1'b0, "slow fetch");
    set_cfg(2'd1, 3'd1);
    run_access(1'b0, 11'd1024, 8'h00, 1'b1, 1'b0, "R9 directed");
    run_access(1'b1, 11'd1023, 8'h80, 1'b0, 1'b1, "R8 directed");
    run_access(1'b0, 11'd1023, 8'h00, 1'b0, 1'b0, "R8 readback");
    for (int k = 0; k < 40; k++) begin
      if ($urandom % 2 == 0) set_cfg(2'($urandom), 3'($urandom));
      run_access(1'($urandom), 11'($urandom), 8'($urandom),
                 ($urandom % 4) == 0, ($urandom % 4) == 0, "random");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule